// File: doc/BRIEF.md
# Indirect Management Register Access Sequencer

This block acts as a hardware master for a management bus on which a device hides its internal registers behind a two-register window. Register 0 of the window holds command and status, with bit 15 acting as the busy flag. Register 1 carries data. A client presents one access at a time: a read or write flag, a 5-bit device address, a 5-bit register address and 16 bits of write data. The block turns that access into the polled sequence of window transactions the device expects. It then reports the read data or an error.

The bus side is an abstract register port. A one-cycle request carries the read/write flag, the bus address, the register number and the write data. The response is a one-cycle acknowledge or error, arriving one or more cycles later, with read data beside the acknowledge. When the configured window bus address is zero, the block skips the window and issues the client's access directly.

The controller is a single state machine:
- `S_IDLE` accepts a request.
- `S_DIR_ISSUE`/`S_DIR_WAIT` perform the direct access.
- `S_PRE_ISSUE`/`S_PRE_WAIT` poll for not-busy before the command.
- `S_WDAT_ISSUE`/`S_WDAT_WAIT` load the data register on writes.
- `S_CMD_ISSUE`/`S_CMD_WAIT` write the command word.
- `S_POST_ISSUE`/`S_POST_WAIT` poll for completion.
- `S_RDAT_ISSUE`/`S_RDAT_WAIT` fetch read data.
- `S_FINISH` raises the completion pulse.

The transitions are as follows:
- Each ISSUE state moves to its WAIT state.
- A WAIT state that sees an error goes to `S_FINISH`.
- A poll that reads busy goes back to its ISSUE state, or to `S_FINISH` with a timeout once the poll limit is spent.
- A poll that reads not-busy goes to the next step of the sequence: `S_WDAT_ISSUE` or `S_CMD_ISSUE` after the first poll, and `S_RDAT_ISSUE` or `S_FINISH` after the second.
- `S_FINISH` returns to `S_IDLE`.

Top module: `mgmt_window_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `bus_req` is 0.
- R2: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` stays low from the next cycle until after `done`, and `req_valid` pulses while it is low start nothing.
- R3: With `cfg_win_addr` equal to 0, an access makes exactly one bus transaction with the client's device address, register, flag and data. A read returns the bus read data.
- R4: A windowed read issues these transactions, all to bus address `cfg_win_addr`, in this order. First, status reads of register 0 until bit 15 reads 0. Next, a write to register 0 of 0x9800 | (dev << 5) | reg. Then, status reads of register 0 until bit 15 reads 0. Last, one read of register 1, whose 16 bits are returned on `rsp_rdata`.
- R5: A windowed write issues these transactions in this order. First, status reads of register 0 until bit 15 is 0. Next, a write of the client data to register 1. Then, a write to register 0 of 0x9400 | (dev << 5) | reg. Last, status reads of register 0 until bit 15 is 0. `rsp_rdata` is 0.
- R6: Each polling phase makes at most 16 status reads. If bit 15 is still 1 on the 16th, the access ends with `rsp_err` = 1 (timeout), `rsp_rdata` = 0, and no further transaction.
- R7: An error response on any transaction ends the access at once with `rsp_err` = 2 (bus error), `rsp_rdata` = 0, and no further transaction.
- R8: `done` is high for exactly one cycle, in the cycle after the final response. `rsp_err` = 0 means success.
- R9: `bus_req` is high for single cycles only, and no new request is issued while a response is outstanding.
- R10: The poll limit applies separately to each polling phase. 15 busy reads before the command and 15 after it still complete successfully.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_win_addr | input | 5 | Bus address of the window; 0 selects direct access |
| req_valid | input | 1 | Client request strobe |
| req_ready | output | 1 | High when a request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Target device address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 2 | 0 none, 1 timeout, 2 bus error |
| rsp_rdata | output | 16 | Read result, valid with `done` |
| bus_req | output | 1 | One-cycle bus transaction request |
| bus_write | output | 1 | Bus transaction is a write |
| bus_addr | output | 5 | Bus address of the transaction |
| bus_reg | output | 5 | Register number of the transaction |
| bus_wdata | output | 16 | Bus write data |
| bus_ack | input | 1 | Successful response |
| bus_err | input | 1 | Error response |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` |

## Verification
The first bus request appears in the cycle after the request is accepted. Each later request appears in the cycle after the response to the one before it. `done` rises in the cycle after the last response. The bench drives and samples on the falling edge. Its bus model stamps the cycle of every response, and the bench checks that `done` appears exactly one cycle after the final stamp and is gone one cycle later. Transaction order, addresses and command words are checked from the model's log after completion. The absence of stray transactions is checked by waiting extra cycles after a pulse or an abort and confirming that the log has not grown.

// File: rtl/mws_pkg.sv
package mws_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int BUSY_BIT = 15;

    localparam logic [ADDR_W-1:0] WIN_CMD_REG  = 5'd0;
    localparam logic [ADDR_W-1:0] WIN_DATA_REG = 5'd1;

    localparam logic [DATA_W-1:0] CMD_BASE = 16'h9000;
    localparam logic [DATA_W-1:0] CMD_OP_RD = 16'h0800;
    localparam logic [DATA_W-1:0] CMD_OP_WR = 16'h0400;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_BUS     = 2'd2
    } err_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DIR_ISSUE,  S_DIR_WAIT,
        S_PRE_ISSUE,  S_PRE_WAIT,
        S_WDAT_ISSUE, S_WDAT_WAIT,
        S_CMD_ISSUE,  S_CMD_WAIT,
        S_POST_ISSUE, S_POST_WAIT,
        S_RDAT_ISSUE, S_RDAT_WAIT,
        S_FINISH
    } state_t;
endpackage

// File: rtl/mws_cmd_fmt.sv
module mws_cmd_fmt
    import mws_pkg::*;
(
    input  logic              is_read,
    input  logic [ADDR_W-1:0] dev,
    input  logic [ADDR_W-1:0] regn,
    output logic [DATA_W-1:0] word
);
    localparam int PAD_W = DATA_W - 2*ADDR_W;

    always_comb begin
        word = CMD_BASE | (is_read ? CMD_OP_RD : CMD_OP_WR)
             | {{PAD_W{1'b0}}, dev, regn};
    end
endmodule

// File: rtl/mws_poll_ctr.sv
module mws_poll_ctr #(
    parameter int MAX_POLLS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic last
);
    localparam int CW = $clog2(MAX_POLLS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LIMIT);

    // R6: a poll phase never counts past its limit
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear) |-> (cnt <= LIMIT));
endmodule

// File: rtl/mgmt_window_seq.sv
module mgmt_window_seq
    import mws_pkg::*;
#(
    parameter int MAX_POLLS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        cfg_win_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [4:0]        req_dev,
    input  logic [4:0]        req_reg,
    input  logic [15:0]       req_wdata,
    output logic              done,
    output logic [1:0]        rsp_err,
    output logic [15:0]       rsp_rdata,
    output logic              bus_req,
    output logic              bus_write,
    output logic [4:0]        bus_addr,
    output logic [4:0]        bus_reg,
    output logic [15:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [15:0]       bus_rdata
);
    state_t state, state_nx;

    logic              wr_q;
    logic [ADDR_W-1:0] dev_q, reg_q, win_q;
    logic [DATA_W-1:0] wdata_q;
    err_t              err_q, err_nx;
    logic [DATA_W-1:0] rdata_q, rdata_nx;
    logic              load_res;

    logic              poll_wait, poll_phase, poll_busy, poll_last;
    logic [DATA_W-1:0] cmd_word;

    mws_cmd_fmt u_fmt (
        .is_read (!wr_q),
        .dev     (dev_q),
        .regn    (reg_q),
        .word    (cmd_word)
    );

    assign poll_wait  = (state == S_PRE_WAIT) || (state == S_POST_WAIT);
    assign poll_phase = poll_wait || (state == S_PRE_ISSUE) || (state == S_POST_ISSUE);
    assign poll_busy  = bus_rdata[BUSY_BIT];

    mws_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!poll_phase),
        .tick  (poll_wait && bus_ack && !bus_err && poll_busy),
        .last  (poll_last)
    );

    // state register and request / result holding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            wr_q    <= 1'b0;
            dev_q   <= '0;
            reg_q   <= '0;
            win_q   <= '0;
            wdata_q <= '0;
            err_q   <= ERR_NONE;
            rdata_q <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && req_valid) begin
                wr_q    <= req_write;
                dev_q   <= req_dev;
                reg_q   <= req_reg;
                win_q   <= cfg_win_addr;
                wdata_q <= req_wdata;
            end
            if (load_res) begin
                err_q   <= err_nx;
                rdata_q <= rdata_nx;
            end
        end
    end

    // next state and result selection
    always_comb begin
        state_nx = state;
        load_res = 1'b0;
        err_nx   = ERR_NONE;
        rdata_nx = '0;
        unique case (state)
            S_IDLE: begin
                if (req_valid)
                    state_nx = (cfg_win_addr == '0) ? S_DIR_ISSUE : S_PRE_ISSUE;
            end
            S_DIR_ISSUE:  state_nx = S_DIR_WAIT;
            S_PRE_ISSUE:  state_nx = S_PRE_WAIT;
            S_WDAT_ISSUE: state_nx = S_WDAT_WAIT;
            S_CMD_ISSUE:  state_nx = S_CMD_WAIT;
            S_POST_ISSUE: state_nx = S_POST_WAIT;
            S_RDAT_ISSUE: state_nx = S_RDAT_WAIT;
            S_DIR_WAIT, S_RDAT_WAIT: begin
                if (bus_err) begin
                    state_nx = S_FINISH; load_res = 1'b1; err_nx = ERR_BUS;
                end else if (bus_ack) begin
                    state_nx = S_FINISH; load_res = 1'b1;
                    rdata_nx = (state == S_RDAT_WAIT || !wr_q) ? bus_rdata : '0;
                end
            end
            S_WDAT_WAIT, S_CMD_WAIT: begin
                if (bus_err) begin
                    state_nx = S_FINISH; load_res = 1'b1; err_nx = ERR_BUS;
                end else if (bus_ack) begin
                    state_nx = (state == S_WDAT_WAIT) ? S_CMD_ISSUE : S_POST_ISSUE;
                end
            end
            S_PRE_WAIT, S_POST_WAIT: begin
                if (bus_err) begin
                    state_nx = S_FINISH; load_res = 1'b1; err_nx = ERR_BUS;
                end else if (bus_ack) begin
                    if (poll_busy) begin
                        if (poll_last) begin
                            state_nx = S_FINISH; load_res = 1'b1; err_nx = ERR_TIMEOUT;
                        end else begin
                            state_nx = (state == S_PRE_WAIT) ? S_PRE_ISSUE : S_POST_ISSUE;
                        end
                    end else if (state == S_PRE_WAIT) begin
                        state_nx = wr_q ? S_WDAT_ISSUE : S_CMD_ISSUE;
                    end else if (wr_q) begin
                        state_nx = S_FINISH; load_res = 1'b1;
                    end else begin
                        state_nx = S_RDAT_ISSUE;
                    end
                end
            end
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state == S_IDLE);
        done      = (state == S_FINISH);
        rsp_err   = err_q;
        rsp_rdata = rdata_q;
        bus_req   = 1'b0;
        bus_write = 1'b0;
        bus_addr  = win_q;
        bus_reg   = WIN_CMD_REG;
        bus_wdata = '0;
        unique case (state)
            S_DIR_ISSUE, S_DIR_WAIT: begin
                bus_req   = (state == S_DIR_ISSUE);
                bus_write = wr_q;
                bus_addr  = dev_q;
                bus_reg   = reg_q;
                bus_wdata = wr_q ? wdata_q : '0;
            end
            S_PRE_ISSUE, S_PRE_WAIT, S_POST_ISSUE, S_POST_WAIT: begin
                bus_req = (state == S_PRE_ISSUE) || (state == S_POST_ISSUE);
            end
            S_WDAT_ISSUE, S_WDAT_WAIT: begin
                bus_req   = (state == S_WDAT_ISSUE);
                bus_write = 1'b1;
                bus_reg   = WIN_DATA_REG;
                bus_wdata = wdata_q;
            end
            S_CMD_ISSUE, S_CMD_WAIT: begin
                bus_req   = (state == S_CMD_ISSUE);
                bus_write = 1'b1;
                bus_wdata = cmd_word;
            end
            S_RDAT_ISSUE, S_RDAT_WAIT: begin
                bus_req = (state == S_RDAT_ISSUE);
                bus_reg = WIN_DATA_REG;
            end
            default: ;
        endcase
    end

    // R9: a bus request never lasts two cycles
    p_req_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> !bus_req);
    // R2: accepting a request drops ready
    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R8: completion is a single-cycle pulse followed by ready
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
    // R7: an error response while waiting ends the access next cycle
    p_err_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !req_ready && !bus_req && !done) |=> (done && rsp_err == 2'd2));
    // R6: a timeout returns zero data
    p_timeout_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_err == 2'd1) |-> (rsp_rdata == '0));
endmodule

// File: tb/mgmt_window_seq_test.sv
module mgmt_window_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_win_addr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [4:0]  req_dev = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [1:0]  rsp_err;
    logic [15:0] rsp_rdata;
    logic        bus_req, bus_write;
    logic [4:0]  bus_addr, bus_reg;
    logic [15:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;
    logic [15:0] bus_rdata = '0;

    mgmt_window_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_win_addr(cfg_win_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
        .done(done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_reg(bus_reg), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bus model state
    int          m_lat = 1;
    int          m_busy = 0;
    int          m_busy_post = 0;
    int          m_err_idx = -1;
    logic [15:0] m_val = 16'h0;
    int          m_nlog = 0;
    int          m_overlap = 0;
    int          m_resp_cyc = 0;
    logic        pend = 1'b0;
    int          wcnt = 0;
    logic        lg_wr [0:63];
    logic [4:0]  lg_addr [0:63];
    logic [4:0]  lg_reg [0:63];
    logic [15:0] lg_wd [0:63];
    logic        p_wr;
    logic [4:0]  p_addr, p_reg;
    logic [15:0] p_wd;
    int          p_idx;

    always @(negedge clk) begin
        bus_ack   <= 1'b0;
        bus_err   <= 1'b0;
        bus_rdata <= 16'h0;
        if (pend) begin
            if (bus_req) m_overlap <= m_overlap + 1;
            if (wcnt == 0) begin
                pend <= 1'b0;
                m_resp_cyc <= cyc;
                if (p_idx == m_err_idx) begin
                    bus_err <= 1'b1;
                end else begin
                    bus_ack <= 1'b1;
                    if (cfg_win_addr == 5'd0 || p_addr != cfg_win_addr) begin
                        bus_rdata <= p_wr ? 16'h0 : m_val;
                    end else if (p_reg == 5'd0) begin
                        if (p_wr) m_busy <= m_busy_post;
                        else if (m_busy > 0) begin
                            bus_rdata <= 16'h8123;
                            m_busy <= m_busy - 1;
                        end else bus_rdata <= 16'h0123;
                    end else if (!p_wr) begin
                        bus_rdata <= m_val;
                    end
                end
            end else wcnt <= wcnt - 1;
        end else if (bus_req) begin
            pend   <= 1'b1;
            wcnt   <= m_lat - 1;
            p_wr   <= bus_write;
            p_addr <= bus_addr;
            p_reg  <= bus_reg;
            p_wd   <= bus_wdata;
            p_idx  <= m_nlog;
            if (m_nlog < 64) begin
                lg_wr[m_nlog]   <= bus_write;
                lg_addr[m_nlog] <= bus_addr;
                lg_reg[m_nlog]  <= bus_reg;
                lg_wd[m_nlog]   <= bus_wdata;
            end
            m_nlog <= m_nlog + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // one access; returns error, read data; checks R8 timing and pulse width
    task automatic access(input logic wr, input logic [4:0] win, input logic [4:0] dev,
                          input logic [4:0] rg, input logic [15:0] wd,
                          input int pre, input int post, input int eidx, input int lat,
                          output logic [1:0] e, output logic [15:0] rd);
        bit got = 0;
        @(negedge clk);
        m_busy = pre; m_busy_post = post; m_err_idx = eidx; m_lat = lat; m_nlog = 0;
        cfg_win_addr = win; req_write = wr; req_dev = dev; req_reg = rg; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        e = 2'd3; rd = 16'hdead;
        for (int i = 0; i < 3000 && !got; i++) begin
            if (done) begin
                got = 1;
                e = rsp_err; rd = rsp_rdata;
                chk("R8 done one cycle after last response", cyc, m_resp_cyc + 1);
            end else @(negedge clk);
        end
        if (!got) chk("R8 done seen", 0, 1);
        @(negedge clk);
        chk("R8 done pulse width", done, 0);
    endtask

    task automatic t_reset();
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 done after reset", done, 0);
        chk("R1 bus_req after reset", bus_req, 0);
    endtask

    task automatic t_direct();
        logic [1:0] e; logic [15:0] rd;
        m_val = 16'hBEEF;
        access(0, 5'd0, 5'd7, 5'd3, 16'h0, 0, 0, -1, 2, e, rd);
        chk("R3 direct read count", m_nlog, 1);
        chk("R3 direct read txn", {lg_wr[0], lg_addr[0], lg_reg[0]}, {1'b0, 5'd7, 5'd3});
        chk("R3 direct read data", rd, 16'hBEEF);
        chk("R3 direct read err", e, 0);
        access(1, 5'd0, 5'd9, 5'd22, 16'h5A5A, 0, 0, -1, 1, e, rd);
        chk("R3 direct write count", m_nlog, 1);
        chk("R3 direct write txn", {lg_wr[0], lg_addr[0], lg_reg[0], lg_wd[0]},
            {1'b1, 5'd9, 5'd22, 16'h5A5A});
    endtask

    task automatic t_win_read();
        logic [1:0] e; logic [15:0] rd;
        m_val = 16'hC0DE;
        access(0, 5'h10, 5'd5, 5'h1A, 16'h0, 2, 3, -1, 3, e, rd);
        chk("R4 read txn count", m_nlog, 2 + 1 + 1 + 3 + 1 + 1);
        chk("R4 first poll", {lg_wr[0], lg_addr[0], lg_reg[0]}, {1'b0, 5'h10, 5'd0});
        chk("R4 command word", {lg_wr[3], lg_addr[3], lg_reg[3], lg_wd[3]},
            {1'b1, 5'h10, 5'd0, 16'h9800 | (16'd5 << 5) | 16'h1A});
        chk("R4 second poll", {lg_wr[7], lg_reg[7]}, {1'b0, 5'd0});
        chk("R4 data fetch", {lg_wr[8], lg_addr[8], lg_reg[8]}, {1'b0, 5'h10, 5'd1});
        chk("R4 read data", rd, 16'hC0DE);
        chk("R4 read err", e, 0);
    endtask

    task automatic t_win_write();
        logic [1:0] e; logic [15:0] rd;
        access(1, 5'h03, 5'd31, 5'd4, 16'h1234, 0, 1, -1, 1, e, rd);
        chk("R5 write txn count", m_nlog, 5);
        chk("R5 first poll", {lg_wr[0], lg_reg[0]}, {1'b0, 5'd0});
        chk("R5 data write", {lg_wr[1], lg_addr[1], lg_reg[1], lg_wd[1]},
            {1'b1, 5'h03, 5'd1, 16'h1234});
        chk("R5 command write", {lg_wr[2], lg_reg[2], lg_wd[2]},
            {1'b1, 5'd0, 16'h9400 | (16'd31 << 5) | 16'd4});
        chk("R5 final polls", {lg_wr[3], lg_reg[3], lg_wr[4], lg_reg[4]}, {1'b0, 5'd0, 1'b0, 5'd0});
        chk("R5 write rdata", rd, 0);
        chk("R5 write err", e, 0);
    endtask

    task automatic t_timeouts();
        logic [1:0] e; logic [15:0] rd;
        int n;
        access(0, 5'h08, 5'd1, 5'd1, 16'h0, 100, 0, -1, 1, e, rd);
        chk("R6 pre timeout count", m_nlog, 16);
        chk("R6 pre timeout err", e, 1);
        chk("R6 pre timeout rdata", rd, 0);
        n = m_nlog;
        repeat (8) @(negedge clk);
        chk("R6 no traffic after timeout", m_nlog, n);
        access(1, 5'h08, 5'd2, 5'd2, 16'h7777, 0, 100, -1, 1, e, rd);
        chk("R6 post timeout count", m_nlog, 3 + 16);
        chk("R6 post timeout err", e, 1);
    endtask

    task automatic t_per_phase_limit();
        logic [1:0] e; logic [15:0] rd;
        m_val = 16'h4242;
        access(0, 5'h11, 5'd6, 5'd7, 16'h0, 15, 15, -1, 1, e, rd);
        chk("R10 txn count", m_nlog, 16 + 1 + 16 + 1);
        chk("R10 err", e, 0);
        chk("R10 data", rd, 16'h4242);
    endtask

    task automatic t_bus_error();
        logic [1:0] e; logic [15:0] rd;
        int n;
        access(0, 5'h02, 5'd3, 5'd3, 16'h0, 0, 0, 1, 2, e, rd);
        chk("R7 abort count", m_nlog, 2);
        chk("R7 abort err", e, 2);
        chk("R7 abort rdata", rd, 0);
        n = m_nlog;
        repeat (8) @(negedge clk);
        chk("R7 no traffic after abort", m_nlog, n);
        access(1, 5'h0, 5'd3, 5'd3, 16'h1, 0, 0, 0, 1, e, rd);
        chk("R7 direct abort err", e, 2);
    endtask

    task automatic t_busy_ignore();
        bit got = 0;
        @(negedge clk);
        m_busy = 0; m_busy_post = 0; m_err_idx = -1; m_lat = 4; m_nlog = 0; m_val = 16'h0AA0;
        cfg_win_addr = 5'h05; req_write = 0; req_dev = 5'd1; req_reg = 5'd2;
        req_valid = 1'b1;
        @(negedge clk);
        req_dev = 5'd20; req_reg = 5'd21; req_write = 1; req_wdata = 16'hFFFF;
        for (int i = 0; i < 5; i++) begin
            chk("R2 ready low while busy", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        for (int i = 0; i < 3000 && !got; i++) begin
            if (done) got = 1; else @(negedge clk);
        end
        chk("R2 first access result", rsp_rdata, 16'h0AA0);
        repeat (10) @(negedge clk);
        chk("R2 extra pulses started nothing", m_nlog, 4);
        chk("R2 command kept first fields", lg_wd[1], 16'h9800 | (16'd1 << 5) | 16'd2);
        chk("R2 ready again", req_ready, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_win_read();
        t_win_write();
        t_timeouts();
        t_per_phase_limit();
        t_bus_error();
        t_busy_ignore();
        chk("R9 no request while response pending", m_overlap, 0);
        finish_run();
    end
endmodule